// File: doc/BRIEF.md
# Multi-Device Sync and Settle Tracker

This block controls the start of a decimating filter so that several converters sharing one master clock and one active-low sync line begin gathering samples on the same clock edge. Every register in the block updates on the falling edge of the master clock, which is the decision edge. The sync line passes through two falling-edge flops before the control logic uses it. While the synchronized level is low, the block keeps the filter in reset and holds its sequence counter at zero.

When sync is released after a long enough low period, the block latches the decimation choice and the settle count. It then starts the sequence counter from zero and produces an output strobe once per output period. After the configured number of output periods, it raises a settled flag. This flag is meant to travel in the top bit of the status byte that goes with each conversion result. A release that follows a low period that is too short is rejected. In that case the filter stays in reset and a violation flag is raised until a valid sync arrives.

The control state machine has four states:
- ST_HOLD: sync mode. Sync is sampled low, or reset is active.
- ST_SETTLING: running, with the settled flag still low.
- ST_SETTLED: running, with the settled flag high.
- ST_INVALID: the low pulse was too short.

Transitions:
- ST_HOLD→ST_SETTLING: a valid release with a nonzero settle count.
- ST_HOLD→ST_SETTLED: a valid release with a zero settle count.
- ST_HOLD→ST_INVALID: a short release.
- ST_SETTLING→ST_SETTLED: the strobe of the final settle period.
- Any state other than ST_HOLD→ST_HOLD: sync sampled low.

Top module: `sync_settle_tracker`

## Requirements
- R1: sync_n is sampled only on falling edges of mclk. A low level that begins after one falling edge and ends before the next has no effect on any output.
- R2: A change on sync_n acts on the third falling edge after it is driven, because of two synchronizer stages plus the state register. While the synchronized level is low, filt_run=0, seq_cnt=0 and out_strobe=0.
- R3: A release counts as valid only if sync was sampled low on at least MIN_LOW (4) decision edges. After a shorter low period, sync_viol=1 and filt_run stays 0 until sync is sampled low again; that next low sample clears sync_viol.
- R4: On a valid release, seq_cnt starts at 0 and increases by one on each falling edge. out_strobe=1 exactly when seq_cnt equals P-1, after which seq_cnt wraps to 0.
- R5: The output period is P=8 clocks when dec_sel=0 and P=16 clocks when dec_sel=1. P is latched at the release edge, and later changes to dec_sel have no effect until the next sync.
- R6: settled rises exactly N*P falling edges after the release edge, where N is settle_cnt latched at that edge. When N=0, settled rises on the release edge itself.
- R7: Changes to settle_cnt after the release edge do not move the settled time.
- R8: rst is synchronous to the falling edge and puts the block in sync mode with a low period already counted as valid. When rst is removed while sync_n is high, running starts on the next falling edge.
- R9: Once settled is high, it stays high until sync is sampled low or rst is applied. Sampling sync low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; the falling edge is the decision edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Active-low sync request shared by all devices |
| dec_sel | input | 1 | Decimation select: 0 gives an 8-clock period, 1 gives a 16-clock period |
| settle_cnt | input | SW (8) | Settle time in output periods |
| seq_cnt | output | CW (4) | Filter sequence position within the output period |
| filt_run | output | 1 | Filter enable; 0 keeps the filter in reset |
| out_strobe | output | 1 | Output-period strobe (frame sync) |
| settled | output | 1 | Filter output is valid |
| sync_viol | output | 1 | The last sync low pulse was too short |

## Verification
Inputs are driven just after a rising edge, and outputs are sampled one rising edge after each decision edge. A sync change therefore shows up at the third sample after it is driven, and release from reset shows up at the first. After a release, the strobe is expected at sample 2+P, the wrap to zero at sample 3+P, and the settled flag at sample 3+N*P. The sample before each of these is also checked, so a result that arrives one edge early or late is caught. Ignored stimulus is checked the same way: an inter-edge glitch, and changes to dec_sel or settle_cnt while running. The bench confirms that the strobe period and the settled time still match the values latched at release.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_HOLD     = 2'd0,
        ST_SETTLING = 2'd1,
        ST_SETTLED  = 2'd2,
        ST_INVALID  = 2'd3
    } sst_state_e;
endpackage

// File: rtl/sst_sync2.sv
// Two-stage falling-edge synchronizer for the sync request.
module sst_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(negedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sst_seq.sv
// Filter sequence counter and output-period strobe.
module sst_seq #(
    parameter int PER_LO = 8,
    parameter int PER_HI = 16,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          run_cur,
    input  logic          run_nxt,
    input  logic          dec_sel,
    output logic [CW-1:0] seq_cnt,
    output logic          strobe
);
    localparam int PW = CW + 1;

    logic [PW-1:0] per_q;

    always_ff @(negedge clk) begin
        if (rst)
            per_q <= PW'(PER_LO);
        else if (start)
            per_q <= dec_sel ? PW'(PER_HI) : PW'(PER_LO);
    end

    always_ff @(negedge clk) begin
        if (rst || start || !run_nxt)
            seq_cnt <= '0;
        else if (strobe)
            seq_cnt <= '0;
        else
            seq_cnt <= seq_cnt + 1'b1;
    end

    assign strobe = run_cur && ({1'b0, seq_cnt} == (per_q - PW'(1)));
endmodule

// File: rtl/sst_settle.sv
// Remaining-settle-period counter, loaded at release.
module sst_settle #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [SW-1:0] settle_in,
    input  logic          strobe,
    output logic          last
);
    logic [SW-1:0] rem;

    always_ff @(negedge clk) begin
        if (rst)
            rem <= '0;
        else if (start)
            rem <= settle_in;
        else if (strobe && (rem != '0))
            rem <= rem - 1'b1;
    end

    assign last = (rem == SW'(1));
endmodule

// File: rtl/sync_settle_tracker.sv
module sync_settle_tracker #(
    parameter int MIN_LOW = 4,
    parameter int PER_LO  = 8,
    parameter int PER_HI  = 16,
    parameter int SW      = 8,
    localparam int CW     = $clog2(PER_HI),
    localparam int LW     = $clog2(MIN_LOW + 1)
) (
    input  logic          mclk,
    input  logic          rst,
    input  logic          sync_n,
    input  logic          dec_sel,
    input  logic [SW-1:0] settle_cnt,
    output logic [CW-1:0] seq_cnt,
    output logic          filt_run,
    output logic          out_strobe,
    output logic          settled,
    output logic          sync_viol
);
    import sst_pkg::*;

    sst_state_e state, state_nxt;
    logic       sync_s;
    logic [LW-1:0] low_cnt;
    logic       low_ok;
    logic       start;
    logic       run_nxt;
    logic       last_per;

    sst_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk (mclk),
        .rst (rst),
        .d   (sync_n),
        .q   (sync_s)
    );

    assign low_ok  = (low_cnt >= LW'(MIN_LOW));
    assign start   = (state == ST_HOLD) && sync_s && low_ok && !rst;
    assign run_nxt = !rst && ((state_nxt == ST_SETTLING) || (state_nxt == ST_SETTLED));

    sst_seq #(.PER_LO(PER_LO), .PER_HI(PER_HI), .CW(CW)) u_seq (
        .clk     (mclk),
        .rst     (rst),
        .start   (start),
        .run_cur (filt_run),
        .run_nxt (run_nxt),
        .dec_sel (dec_sel),
        .seq_cnt (seq_cnt),
        .strobe  (out_strobe)
    );

    sst_settle #(.SW(SW)) u_settle (
        .clk       (mclk),
        .rst       (rst),
        .start     (start),
        .settle_in (settle_cnt),
        .strobe    (out_strobe),
        .last      (last_per)
    );

    // Low-period counter, saturating at MIN_LOW
    always_ff @(negedge mclk) begin
        if (rst)
            low_cnt <= LW'(MIN_LOW);
        else if (!sync_s) begin
            if (state != ST_HOLD)
                low_cnt <= LW'(1);
            else if (!low_ok)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (sync_s) begin
                    if (!low_ok)
                        state_nxt = ST_INVALID;
                    else if (settle_cnt == '0)
                        state_nxt = ST_SETTLED;
                    else
                        state_nxt = ST_SETTLING;
                end
            end
            ST_SETTLING: begin
                if (!sync_s)
                    state_nxt = ST_HOLD;
                else if (out_strobe && last_per)
                    state_nxt = ST_SETTLED;
            end
            ST_SETTLED: begin
                if (!sync_s)
                    state_nxt = ST_HOLD;
            end
            ST_INVALID: begin
                if (!sync_s)
                    state_nxt = ST_HOLD;
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(negedge mclk) begin
        if (rst)
            state <= ST_HOLD;
        else
            state <= state_nxt;
    end

    // Outputs decoded from state
    always_comb begin
        filt_run  = 1'b0;
        settled   = 1'b0;
        sync_viol = 1'b0;
        unique case (state)
            ST_HOLD:     ;
            ST_SETTLING: filt_run = 1'b1;
            ST_SETTLED: begin
                filt_run = 1'b1;
                settled  = 1'b1;
            end
            ST_INVALID:  sync_viol = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
    parameter int CW = 4
) (
    input logic          mclk,
    input logic          rst,
    input logic [CW-1:0] seq_cnt,
    input logic          filt_run,
    input logic          out_strobe,
    input logic          settled,
    input logic          sync_viol
);
    AST_HOLD_ZERO: assert property (@(negedge mclk) disable iff (rst)
        !filt_run |-> (seq_cnt == '0) && !out_strobe); // R2

    AST_SEQ_STEP: assert property (@(negedge mclk) disable iff (rst)
        (filt_run && $past(filt_run) && !$past(out_strobe))
            |-> (seq_cnt == CW'($past(seq_cnt) + 1'b1))); // R4

    AST_STROBE_WRAP: assert property (@(negedge mclk) disable iff (rst)
        out_strobe |=> (seq_cnt == '0)); // R4

    AST_SETTLED_RUN: assert property (@(negedge mclk) disable iff (rst)
        settled |-> filt_run); // R6

    AST_VIOL_IDLE: assert property (@(negedge mclk) disable iff (rst)
        sync_viol |-> (!filt_run && !settled)); // R3

    AST_SETTLED_KEEP: assert property (@(negedge mclk) disable iff (rst)
        ($past(settled) && filt_run) |-> settled); // R9
endmodule

bind sync_settle_tracker sst_checker #(.CW(CW)) u_chk (
    .mclk       (mclk),
    .rst        (rst),
    .seq_cnt    (seq_cnt),
    .filt_run   (filt_run),
    .out_strobe (out_strobe),
    .settled    (settled),
    .sync_viol  (sync_viol)
);

// File: tb/tb_sync_settle_tracker.sv
module tb_sync_settle_tracker;
    logic       mclk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_n = 1'b1;
    logic       dec_sel = 1'b0;
    logic [7:0] settle_cnt = 8'd2;
    logic [3:0] seq_cnt;
    logic       filt_run, out_strobe, settled, sync_viol;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    sync_settle_tracker dut (
        .mclk(mclk), .rst(rst), .sync_n(sync_n), .dec_sel(dec_sel),
        .settle_cnt(settle_cnt), .seq_cnt(seq_cnt), .filt_run(filt_run),
        .out_strobe(out_strobe), .settled(settled), .sync_viol(sync_viol)
    );

    always #4 mclk = ~mclk;

    task automatic tick(int n);
        repeat (n) @(posedge mclk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Follow a start: lat = sample at which running is first seen.
    task automatic follow(int lat, int per, int n, bit scramble);
        int stop = lat + ((n > 0) ? n * per : per) + 1;
        for (int k = 1; k <= stop; k++) begin
            tick(1);
            if (k == lat) begin
                chk("R4", "filt_run at start", int'(filt_run), 1);
                chk("R4", "seq_cnt at start", int'(seq_cnt), 0);
                if (n == 0) chk("R6", "settled with N=0", int'(settled), 1);
                if (scramble) begin
                    dec_sel = ~dec_sel;
                    settle_cnt = 8'd9;
                end
            end
            if (k == lat + per - 2) chk("R5", "no strobe before P-1", int'(out_strobe), 0);
            if (k == lat + per - 1) begin
                chk("R5", "strobe at P-1", int'(out_strobe), 1);
                chk("R4", "seq_cnt at P-1", int'(seq_cnt), per - 1);
            end
            if (k == lat + per) chk("R4", "seq_cnt wrap", int'(seq_cnt), 0);
            if (n > 0 && k == lat + n * per - 1)
                chk(scramble ? "R7" : "R6", "settled early", int'(settled), 0);
            if (n > 0 && k == lat + n * per)
                chk(scramble ? "R7" : "R6", "settled on time", int'(settled), 1);
        end
    endtask

    task automatic t_reset();
        tick(3);
        chk("R8", "reset filt_run", int'(filt_run), 0);
        chk("R8", "reset seq_cnt", int'(seq_cnt), 0);
        chk("R8", "reset settled", int'(settled), 0);
        chk("R8", "reset strobe", int'(out_strobe), 0);
        chk("R8", "reset sync_viol", int'(sync_viol), 0);
        dec_sel = 1'b0;
        settle_cnt = 8'd2;
        rst = 1'b0;
        follow(1, 8, 2, 1'b0);
    endtask

    task automatic do_sync(int lows);
        sync_n = 1'b0;
        tick(lows);
        sync_n = 1'b1;
    endtask

    task automatic t_slow_latched();
        dec_sel = 1'b1;
        settle_cnt = 8'd2;
        do_sync(4);
        follow(3, 16, 2, 1'b1);
        tick(20);
        chk("R9", "settled holds", int'(settled), 1);
        chk("R5", "period kept at 16", int'(out_strobe), int'(seq_cnt == 4'd15));
    endtask

    task automatic t_clear_on_sync();
        sync_n = 1'b0;
        tick(2);
        chk("R2", "settled before latency", int'(settled), 1);
        tick(1);
        chk("R9", "settled cleared by sync", int'(settled), 0);
        chk("R2", "filt_run held", int'(filt_run), 0);
        tick(5);
        chk("R2", "seq_cnt held", int'(seq_cnt), 0);
        chk("R2", "strobe held", int'(out_strobe), 0);
        dec_sel = 1'b0;
        settle_cnt = 8'd3;
        sync_n = 1'b1;
        follow(3, 8, 3, 1'b0);
    endtask

    task automatic t_short_pulse();
        do_sync(3);
        tick(3);
        chk("R3", "short pulse flagged", int'(sync_viol), 1);
        chk("R3", "short pulse no run", int'(filt_run), 0);
        tick(10);
        chk("R3", "still invalid", int'(sync_viol), 1);
        chk("R3", "seq_cnt idle", int'(seq_cnt), 0);
        sync_n = 1'b0;
        tick(3);
        chk("R3", "viol cleared", int'(sync_viol), 0);
        tick(1);
        sync_n = 1'b1;
        settle_cnt = 8'd1;
        follow(3, 8, 1, 1'b0);
    endtask

    task automatic t_zero_settle();
        settle_cnt = 8'd0;
        do_sync(5);
        follow(3, 8, 0, 1'b0);
    endtask

    task automatic t_glitch();
        int s0;
        tick(1);
        s0 = int'(seq_cnt);
        sync_n = 1'b0;
        #2;
        sync_n = 1'b1;
        tick(5);
        chk("R1", "glitch keeps run", int'(filt_run), 1);
        chk("R1", "glitch keeps seq", int'(seq_cnt), (s0 + 5) % 8);
        chk("R1", "glitch keeps settled", int'(settled), 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_slow_latched();
                t_clear_on_sync();
                t_short_pulse();
                t_zero_settle();
                t_glitch();
                done = 1'b1;
            end
            begin
                #(200000 * 8);
                if (!done) begin
                    vectors++;
                    fails++;
                    $display("FAIL watchdog: got 0 expected 1");
                end
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule